// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block carries 36-bit words from a producer clocked by `wr_clk` to a consumer clocked by `rd_clk`. The two clocks run freely and may be unrelated or the same. It stores up to 64 words. Each side sees only flags that belong to its own clock. The write side has an active-low full flag and an active-low almost-full flag. The read side has an active-low empty flag and an active-low almost-empty flag.

Each side keeps a binary pointer that carries one extra wrap bit. It sends the Gray-coded form of that pointer to the other side through a two-flop synchronizer. One threshold X sets both almost flags. X comes from a 2-bit select (`thr_sel`). Each side captures the select while reset is held low and keeps that value after reset is released. The read port is registered: a word is loaded into `rd_data` on the read-clock edge that accepts the read.

Top module: `dcfifo_pf`

## Requirements
- R1: While `rst_n` is low, `empty_n`, `aempty_n` and `full_n` are 0, `afull_n` is 1 and `rd_data` is 0.
- R2: `full_n` stays 0 after the first `wr_clk` edge that samples `rst_n` high, and rises to 1 on the second such edge.
- R3: Words come out in the order they were written, and the buffer holds 64 words.
- R4: `full_n` is 0 exactly while 64 words are stored. A write attempted while it is 0 is dropped and leaves the stored contents unchanged.
- R5: `empty_n` is 0 while no word is stored. A read attempted while it is 0 leaves `rd_data` unchanged and does not use up a word.
- R6: With coincident clocks, after a word is written into an empty buffer, `empty_n` rises on the second `rd_clk` edge after the write edge.
- R7: `rd_data` changes only on an accepted read, and then shows the word taken by that same edge.
- R8: `aempty_n` is 0 whenever the word count seen by the read side is at most X.
- R9: `afull_n` is 0 whenever the number of free locations seen by the write side is at most X.
- R10: X is 16, 12, 8 or 4 for `thr_sel` codes 00, 01, 10 or 11, taken from the value held while in reset. Changes to `thr_sel` after reset have no effect.
- R11: The pointer copies that cross between clock domains change by at most one bit per edge (Gray code).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously by both clocks |
| thr_sel | input | 2 | Threshold select, captured while in reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word |
| full_n | output | 1 | Low when full or just out of reset |
| afull_n | output | 1 | Low when free locations are at most X |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered read word |
| empty_n | output | 1 | Low when empty |
| aempty_n | output | 1 | Low when stored words are at most X |

## Verification
The assertions assume that `rst_n` is held low for at least two edges of each clock, so that the synchronizers and the captured threshold settle in both domains. They also assume that the requests are driven synchronously to their own clocks. The bench runs both clocks at the same rate and phase, drives every input just after a falling edge, and holds reset for three cycles. This makes the two-edge flag delays land on exact cycles. Requests made while full or empty are issued on purpose, because the design must drop them.

// File: rtl/dcfifo_pf_pkg.sv
// Shared constants and helpers for the dual-clock FIFO.
// Assumes pointer widths up to 32 bits.
package dcfifo_pf_pkg;

    // Binary to Gray code conversion
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Gray to binary conversion over the full 32-bit field
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int s = 1; s < 32; s = s * 2) begin
            b = b ^ (b >> s);
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
// Two-flop synchronizer for a Gray-coded bus.
// Assumes the source changes at most one bit per source-clock edge.
module dcfifo_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two-stage capture into the destination clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcfifo_ram.sv
// Storage array: a write port on wr_clk and a registered read port on rd_clk.
// Assumes the controllers never enable a write to a slot that is being read.
module dcfifo_ram #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_ok,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted write
    always_ff @(posedge wr_clk) begin
        if (wr_ok) mem[waddr] <= wdata;
    end

    // Load the output register on an accepted read
    always_ff @(posedge rd_clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_ok) rdata <= mem[raddr];
    end

    // R7
    rdata_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_ok |=> $stable(rdata));
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
// Write-side controller: write pointer, full and almost-full flags, threshold capture.
// Assumes rd_gray_s is the read pointer already synchronized to wr_clk.
module dcfifo_wr_ctrl #(
    parameter int ADDR_W = 6,
    parameter int OFS0   = 16,
    parameter int OFS1   = 12,
    parameter int OFS2   = 8,
    parameter int OFS3   = 4,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        thr_sel,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  rd_gray_s,
    output logic              wr_ok,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wr_gray,
    output logic              full_n,
    output logic              afull_n
);
    import dcfifo_pf_pkg::*;

    localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1 << ADDR_W);

    logic [PTR_W-1:0] wbin, wbin_nx, rbin_s, used, free, thr;
    logic [1:0]       ready;
    logic             full;

    assign wbin_nx = wbin + PTR_W'(1);
    assign rbin_s  = PTR_W'(from_gray(32'(rd_gray_s)));
    assign used    = wbin - rbin_s;
    assign free    = DEPTH - used;
    assign full    = (wr_gray == {~rd_gray_s[PTR_W-1:PTR_W-2], rd_gray_s[PTR_W-3:0]});
    assign full_n  = ready[1] & ~full;
    assign afull_n = ~(free <= thr);
    assign wr_ok   = wr_en & full_n;
    assign waddr   = wbin[ADDR_W-1:0];

    // Pointer advance, release delay and threshold capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin    <= '0;
            wr_gray <= '0;
            ready   <= 2'b00;
            case (thr_sel)
                2'b00:   thr <= PTR_W'(OFS0);
                2'b01:   thr <= PTR_W'(OFS1);
                2'b10:   thr <= PTR_W'(OFS2);
                default: thr <= PTR_W'(OFS3);
            endcase
        end else begin
            ready <= {ready[0], 1'b1};
            if (wr_ok) begin
                wbin    <= wbin_nx;
                wr_gray <= PTR_W'(to_gray(32'(wbin_nx)));
            end
        end
    end

    // R4
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full_n) |=> $stable(wbin));
    // R11
    wr_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1));
    // R9
    full_implies_afull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready[1] && !full_n) |-> !afull_n);
    // R2
    full_release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !full_n);
    // R10
    wr_thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(thr));
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
// Read-side controller: read pointer, empty and almost-empty flags, threshold capture.
// Assumes wr_gray_s is the write pointer already synchronized to rd_clk.
module dcfifo_rd_ctrl #(
    parameter int ADDR_W = 6,
    parameter int OFS0   = 16,
    parameter int OFS1   = 12,
    parameter int OFS2   = 8,
    parameter int OFS3   = 4,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        thr_sel,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  wr_gray_s,
    output logic              rd_ok,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rd_gray,
    output logic              empty_n,
    output logic              aempty_n
);
    import dcfifo_pf_pkg::*;

    logic [PTR_W-1:0] rbin, rbin_nx, wbin_s, used, thr;

    assign rbin_nx  = rbin + PTR_W'(1);
    assign wbin_s   = PTR_W'(from_gray(32'(wr_gray_s)));
    assign used     = wbin_s - rbin;
    assign empty_n  = (rd_gray != wr_gray_s);
    assign aempty_n = ~(used <= thr);
    assign rd_ok    = rd_en & empty_n;
    assign raddr    = rbin[ADDR_W-1:0];

    // Pointer advance and threshold capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin    <= '0;
            rd_gray <= '0;
            case (thr_sel)
                2'b00:   thr <= PTR_W'(OFS0);
                2'b01:   thr <= PTR_W'(OFS1);
                2'b10:   thr <= PTR_W'(OFS2);
                default: thr <= PTR_W'(OFS3);
            endcase
        end else if (rd_ok) begin
            rbin    <= rbin_nx;
            rd_gray <= PTR_W'(to_gray(32'(rbin_nx)));
        end
    end

    // R5
    no_read_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty_n) |=> $stable(rbin));
    // R11
    rd_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(rd_gray ^ $past(rd_gray)) <= 1));
    // R8
    empty_implies_aempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);
    // R10
    rd_thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(thr));
endmodule

// File: rtl/dcfifo_pf.sv
// Top level of the dual-clock FIFO: wires together the two controllers,
// the two pointer synchronizers and the storage array.
// Assumes rst_n is held low for at least two edges of each clock.
module dcfifo_pf #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6,
    parameter int OFS0   = 16,
    parameter int OFS1   = 12,
    parameter int OFS2   = 8,
    parameter int OFS3   = 4
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [1:0]        thr_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PTR_W = ADDR_W + 1;

    logic              wr_ok, rd_ok;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_s, rd_gray_s;

    dcfifo_wr_ctrl #(.ADDR_W(ADDR_W), .OFS0(OFS0), .OFS1(OFS1), .OFS2(OFS2), .OFS3(OFS3)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .thr_sel(thr_sel), .wr_en(wr_en),
        .rd_gray_s(rd_gray_s), .wr_ok(wr_ok), .waddr(waddr), .wr_gray(wr_gray),
        .full_n(full_n), .afull_n(afull_n)
    );

    dcfifo_rd_ctrl #(.ADDR_W(ADDR_W), .OFS0(OFS0), .OFS1(OFS1), .OFS2(OFS2), .OFS3(OFS3)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .thr_sel(thr_sel), .rd_en(rd_en),
        .wr_gray_s(wr_gray_s), .rd_ok(rd_ok), .raddr(raddr), .rd_gray(rd_gray),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    dcfifo_sync #(.W(PTR_W)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s)
    );

    dcfifo_sync #(.W(PTR_W)) u_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s)
    );

    dcfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk(wr_clk), .wr_ok(wr_ok), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_ok(rd_ok), .raddr(raddr), .rdata(rd_data)
    );

    // R1
    reset_flags_chk: assert property (@(posedge rd_clk)
        !rst_n |=> (!empty_n && !aempty_n) || rst_n);
endmodule

// File: tb/dcfifo_pf_tb.sv
// Directed bench for dcfifo_pf: coincident 50 MHz clocks, checks at falling edges.
module dcfifo_pf_tb;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  thr_sel = 2'b00;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        full_n, afull_n, empty_n, aempty_n;
    logic [35:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #10 wr_clk = ~wr_clk;
    always #10 rd_clk = ~rd_clk;

    dcfifo_pf u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .thr_sel(thr_sel),
        .wr_en(wr_en), .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n),
        .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    function automatic logic [35:0] pat(input int i);
        return 36'h9_0000_0000 ^ 36'(i * 32'h0001_0003);
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge wr_clk);
    endtask

    task automatic do_reset(input logic [1:0] sel);
        rst_n = 1'b0; thr_sel = sel; wr_en = 1'b0; rd_en = 1'b0;
        idle(3);
        check("R1 empty_n", 36'(empty_n), 36'd0);
        check("R1 aempty_n", 36'(aempty_n), 36'd0);
        check("R1 full_n", 36'(full_n), 36'd0);
        check("R1 afull_n", 36'(afull_n), 36'd1);
        check("R1 rd_data", rd_data, 36'd0);
        rst_n = 1'b1;
        idle(1);
        check("R2 full_n first edge", 36'(full_n), 36'd0);
        idle(1);
        check("R2 full_n second edge", 36'(full_n), 36'd1);
    endtask

    task automatic push_burst(input int n, input int base);
        wr_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            wr_data = pat(base + i);
            @(negedge wr_clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic pop_burst(input int n, input int base, input string req);
        rd_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            check(req, rd_data, pat(base + i));
        end
        rd_en = 1'b0;
    endtask

    // R6, R7, R5: empty-flag delay, registered read, ignored reads when empty
    task automatic t_empty_path();
        do_reset(2'b00);
        push_burst(1, 100);
        check("R6 empty_n after write edge", 36'(empty_n), 36'd0);
        idle(1);
        check("R6 empty_n after first read edge", 36'(empty_n), 36'd0);
        idle(1);
        check("R6 empty_n after second read edge", 36'(empty_n), 36'd1);
        check("R7 rd_data before read", rd_data, 36'd0);
        pop_burst(1, 100, "R7 word on accepting edge");
        check("R5 empty_n after last read", 36'(empty_n), 36'd0);
        rd_en = 1'b1;
        idle(3);
        rd_en = 1'b0;
        check("R5 rd_data held on empty read", rd_data, pat(100));
        push_burst(1, 101);
        idle(3);
        pop_burst(1, 101, "R5 no word consumed by empty read");
    endtask

    // R3, R4: fill to 64, drop extra writes, drain in order
    task automatic t_fill();
        do_reset(2'b00);
        push_burst(63, 0);
        check("R4 full_n at 63", 36'(full_n), 36'd1);
        push_burst(1, 63);
        check("R4 full_n at 64", 36'(full_n), 36'd0);
        check("R9 afull_n at 64", 36'(afull_n), 36'd0);
        wr_en = 1'b1; wr_data = 36'hB_AD0B_AD0B;
        idle(3);
        wr_en = 1'b0;
        idle(1);
        pop_burst(64, 0, "R3 order and capacity");
        check("R5 empty_n after drain", 36'(empty_n), 36'd0);
        rd_en = 1'b1;
        idle(2);
        rd_en = 1'b0;
        check("R4 dropped write not stored", rd_data, pat(63));
        check("R4 full_n released", 36'(full_n), 36'd1);
    endtask

    // R8: almost-empty threshold with X = 16
    task automatic t_aempty();
        do_reset(2'b00);
        push_burst(16, 200);
        idle(3);
        check("R8 aempty_n at 16 words", 36'(aempty_n), 36'd0);
        push_burst(1, 216);
        idle(2);
        check("R8 aempty_n at 17 words", 36'(aempty_n), 36'd1);
        pop_burst(1, 200, "R8 data");
        check("R8 aempty_n back at 16", 36'(aempty_n), 36'd0);
    endtask

    // R9, R10: almost-full boundary for one preset, select changed after reset
    task automatic t_afull(input logic [1:0] sel, input int x);
        do_reset(sel);
        thr_sel = ~sel;
        push_burst(63 - x, 0);
        check("R10 afull_n free X+1", 36'(afull_n), 36'd1);
        push_burst(1, 63 - x);
        check("R9 afull_n free X", 36'(afull_n), 36'd0);
        check("R9 full_n not full", 36'(full_n), 36'd1);
    endtask

    // R11: several pointer wraps with data kept intact
    task automatic t_wrap();
        do_reset(2'b01);
        for (int r = 0; r < 3; r++) begin
            push_burst(50, 300 + 50 * r);
            idle(3);
            pop_burst(50, 300 + 50 * r, "R11 data across pointer wrap");
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(1);
        t_empty_path();
        t_fill();
        t_aempty();
        t_afull(2'b00, 16);
        t_afull(2'b01, 12);
        t_afull(2'b10, 8);
        t_afull(2'b11, 4);
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule